// File: doc/BRIEF.md
# Serial/Parallel Gain-Step Control Interface

This block is the digital front end that sets a 6-bit stepped gain control word. The word can arrive in two ways, chosen by a mode pin. In serial mode a 3-wire interface is used: data, a slow serial clock and a latch strobe. In parallel mode a 6-bit bus is used, either passed straight through or captured on the latch strobe. Every input is sampled by the block's own system clock. A rising serial clock is found by comparing the serial clock with its value one system clock earlier.

The control word is active low and binary weighted. Each bit that is low takes its weight off the gain, and the weights are 0.5, 1, 2, 4, 8 and 16 dB. A signed count of half-dB steps is decoded from the word for checking.

After reset, a power-up timer counts a parameterised number of cycles. When it expires, the block loads an initial word. That word comes from two select pins if the latch strobe is low at that moment, or from the parallel bus if it is high. A serial output carries the bit that falls out of the top of the shift register, so that further devices can be chained behind this one.

Top module: `gain_step_ctrl`

## Requirements
- R1: In serial mode (`mode_serial`=1) with `latch_en` low, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 6-bit shift register, and the older bits move toward bit 5. The word is therefore loaded MSB first, and after six rising edges the first bit sent sits in bit 5.
- R2: In serial mode with `latch_en` high, and after power-up, `ctrl_word` takes the shift register contents one clock later. While `latch_en` is high, `ser_clk` edges do not shift.
- R3: In parallel mode (`mode_serial`=0), `ser_data`, `ser_clk` and `latch_en` have no effect on the shift register. A later serial transfer still delivers the word that was held before parallel mode was entered.
- R4: In parallel mode with `latch_en` held high, `ctrl_word` equals `par_word` one clock later.
- R5: After power-up, in every mode, `ctrl_word` does not change while `latch_en` is low. In parallel mode a one-cycle `latch_en` pulse captures the `par_word` present during that pulse.
- R6: `gain_halfdb` equals minus the unsigned value of the inverted `ctrl_word`. Examples: 6'h3F gives 0, 6'h00 gives -63, and clearing only bit k gives -(2^k).
- R7: When the power-up timer expires with `latch_en` low, `ctrl_word` loads a value chosen by {`pu_sel_b`,`pu_sel_a`}. The values are 00 -> 6'b000000 (-31.5 dB), 01 -> 6'b001111 (-24 dB), 10 -> 6'b011111 (-16 dB) and 11 -> 6'b111111 (0 dB).
- R8: When the power-up timer expires with `latch_en` high, `ctrl_word` loads `par_word`.
- R9: Synchronous reset sets `ctrl_word` to 6'b000000 and clears the shift register. `ctrl_word` then stays at 6'b000000 until the PU_CYCLES-th clock edge after reset is released, and `latch_en` transfers before that edge are ignored.
- R10: `ser_out` equals bit 5 of the shift register and changes on the same clock edge as the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; models power-on |
| mode_serial | input | 1 | 1 = serial mode, 0 = parallel mode |
| ser_data | input | 1 | Serial data input |
| ser_clk | input | 1 | Serial clock; a rising edge shifts |
| latch_en | input | 1 | Latch strobe; high transfers, low holds |
| par_word | input | 6 | Parallel control word |
| pu_sel_a | input | 1 | Power-up select, low-order pin |
| pu_sel_b | input | 1 | Power-up select, high-order pin |
| ser_out | output | 1 | Serial output for chaining (shift register bit 5) |
| ctrl_word | output | 6 | Registered active-low control word |
| gain_halfdb | output | 7 | Signed relative gain in 0.5 dB steps |

## Verification
The bench resets the block once for each of the four select-pin codes and once with the strobe high. It checks that the word stays at zero up to the edge before the timer expires, even with the strobe high and a non-zero bus. A design whose timer is off by one, or that lets early strobes through, fails this check. It also sends serial clock edges while the strobe is high and while the block is in parallel mode, then checks that a later transfer still delivers the old word. A design that does not mask those edges delivers a corrupted word. Finally it chains two serial words and checks that the first word comes out of the serial output, most significant bit first. This catches a shift in the wrong direction or a serial output taken from the wrong end of the register.

// File: rtl/gain_step_pkg.sv
package gain_step_pkg;
  localparam int CODE_W = 6;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic signed [CODE_W:0] steps_t;

  // power-up word chosen by the select pins {b,a}
  function automatic code_t pup_code(input logic sel_a, input logic sel_b);
    code_t c;
    case ({sel_b, sel_a})
      2'b00:   c = 6'b000000;
      2'b01:   c = 6'b001111;
      2'b10:   c = 6'b011111;
      default: c = 6'b111111;
    endcase
    return c;
  endfunction

  // active-low binary weighted code to signed half-dB steps
  function automatic steps_t code_to_steps(input code_t c);
    steps_t mag;
    mag = $signed({1'b0, ~c});
    return -mag;
  endfunction
endpackage

// File: rtl/gain_ser_shift.sv
module gain_ser_shift
  import gain_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  shift_ok,
  input  logic  sdi,
  input  logic  sclk,
  output code_t shift_q,
  output logic  shift_evt,
  output logic  sdo
);
  logic sclk_q;

  assign shift_evt = shift_ok & sclk & ~sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      shift_q <= '0;
    end else begin
      sclk_q <= sclk;
      if (shift_evt) shift_q <= {shift_q[CODE_W-2:0], sdi};
    end
  end

  assign sdo = shift_q[CODE_W-1];
endmodule

// File: rtl/gain_pu_timer.sv
module gain_pu_timer #(
  parameter int PU_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic ready,
  output logic fire
);
  localparam int CNT_W = $clog2(PU_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PU_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign fire = ~ready & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (fire) begin
      ready <= 1'b1;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gain_ctrl_reg.sv
module gain_ctrl_reg
  import gain_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pu_fire,
  input  logic  pu_ready,
  input  logic  latch_en,
  input  code_t init_word,
  input  code_t xfer_word,
  output code_t ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)                      ctrl_q <= '0;
    else if (pu_fire)             ctrl_q <= init_word;
    else if (pu_ready && latch_en) ctrl_q <= xfer_word;
  end
endmodule

// File: rtl/gain_step_ctrl.sv
module gain_step_ctrl
  import gain_step_pkg::*;
#(
  parameter int PU_CYCLES = 20_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_serial,
  input  logic        ser_data,
  input  logic        ser_clk,
  input  logic        latch_en,
  input  logic [5:0]  par_word,
  input  logic        pu_sel_a,
  input  logic        pu_sel_b,
  output logic        ser_out,
  output logic [5:0]  ctrl_word,
  output logic signed [6:0] gain_halfdb
);
  code_t shift_q, init_word, xfer_word;
  logic  shift_evt, pu_ready, pu_fire;

  gain_ser_shift u_shift (
    .clk(clk), .rst(rst), .shift_ok(mode_serial & ~latch_en),
    .sdi(ser_data), .sclk(ser_clk),
    .shift_q(shift_q), .shift_evt(shift_evt), .sdo(ser_out)
  );

  gain_pu_timer #(.PU_CYCLES(PU_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .ready(pu_ready), .fire(pu_fire)
  );

  assign init_word = latch_en ? code_t'(par_word) : pup_code(pu_sel_a, pu_sel_b);
  assign xfer_word = mode_serial ? shift_q : code_t'(par_word);

  gain_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .pu_fire(pu_fire), .pu_ready(pu_ready),
    .latch_en(latch_en), .init_word(init_word), .xfer_word(xfer_word),
    .ctrl_q(ctrl_word)
  );

  assign gain_halfdb = code_to_steps(ctrl_word);
endmodule

// File: rtl/gain_step_ctrl_chk.sv
module gain_step_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_serial,
  input logic       ser_data,
  input logic       latch_en,
  input logic [5:0] par_word,
  input logic [5:0] shift_q,
  input logic       shift_evt,
  input logic       pu_ready,
  input logic       pu_fire,
  input logic [5:0] ctrl_word
);
  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> shift_q == {$past(shift_q[4:0]), $past(ser_data)}); // R1

  AST_SER_XFER: assert property (@(posedge clk) disable iff (rst)
    (pu_ready && mode_serial && latch_en) |=> ctrl_word == $past(shift_q)); // R2

  AST_SCLK_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mode_serial && latch_en) |=> $stable(shift_q)); // R2

  AST_PAR_IGNORES_SER: assert property (@(posedge clk) disable iff (rst)
    !mode_serial |=> $stable(shift_q)); // R3

  AST_DIRECT_PAR: assert property (@(posedge clk) disable iff (rst)
    (pu_ready && !mode_serial && latch_en) |=> ctrl_word == $past(par_word)); // R4

  AST_HOLD_LE_LOW: assert property (@(posedge clk) disable iff (rst)
    (pu_ready && !latch_en) |=> $stable(ctrl_word)); // R5

  AST_NO_EARLY_XFER: assert property (@(posedge clk) disable iff (rst)
    (!pu_ready && !pu_fire) |=> $stable(ctrl_word)); // R9
endmodule

bind gain_step_ctrl gain_step_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mode_serial(mode_serial), .ser_data(ser_data),
  .latch_en(latch_en), .par_word(par_word), .shift_q(shift_q),
  .shift_evt(shift_evt), .pu_ready(pu_ready), .pu_fire(pu_fire),
  .ctrl_word(ctrl_word)
);

// File: tb/test_gain_step_ctrl.sv
module test_gain_step_ctrl;
  localparam int PU = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_serial = 1'b0, ser_data = 1'b0, ser_clk = 1'b0, latch_en = 1'b0;
  logic [5:0] par_word = '0;
  logic pu_sel_a = 1'b0, pu_sel_b = 1'b0;
  logic ser_out;
  logic [5:0] ctrl_word;
  logic signed [6:0] gain_halfdb;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  gain_step_ctrl #(.PU_CYCLES(PU)) i_gain_step_ctrl (
    .clk(clk), .rst(rst), .mode_serial(mode_serial), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_en(latch_en), .par_word(par_word),
    .pu_sel_a(pu_sel_a), .pu_sel_b(pu_sel_b), .ser_out(ser_out),
    .ctrl_word(ctrl_word), .gain_halfdb(gain_halfdb)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // {par_word[5:0], expected gain[6:0]}  (R4, R6)
  localparam logic [12:0] VEC [10] = '{
    {6'h3F, 7'sd0},   {6'h3E, -7'sd1},  {6'h3D, -7'sd2},  {6'h3B, -7'sd4},
    {6'h37, -7'sd8},  {6'h2F, -7'sd16}, {6'h1F, -7'sd32}, {6'h00, -7'sd63},
    {6'h15, -7'sd42}, {6'h2A, -7'sd21}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b; ser_clk = 1'b1;
    cyc(1);
    ser_clk = 1'b0;
    cyc(1);
  endtask

  task automatic pulse_le();
    latch_en = 1'b1;
    cyc(1);
    latch_en = 1'b0;
    cyc(1);
  endtask

  task automatic powerup(input logic a, input logic b, input logic le,
                         input logic [5:0] par, input logic [5:0] exp, input string req);
    rst = 1'b1; mode_serial = 1'b0; latch_en = le; pu_sel_a = a; pu_sel_b = b;
    par_word = par; ser_clk = 1'b0;
    cyc(3);
    chk("R9 reset word", int'(ctrl_word), 0);
    rst = 1'b0;
    cyc(PU - 1);
    chk("R9 held before timer", int'(ctrl_word), 0);
    cyc(1);
    chk(req, int'(ctrl_word), int'(exp));
    cyc(3);
    chk(req, int'(ctrl_word), int'(exp));
  endtask

  initial begin
    logic [5:0] w1, w2;
    w1 = 6'b101101;
    w2 = 6'b010011;

    cyc(1);
    powerup(1'b0, 1'b0, 1'b0, 6'h2A, 6'b000000, "R7 sel 00");
    powerup(1'b0, 1'b1, 1'b0, 6'h2A, 6'b011111, "R7 sel 10");
    powerup(1'b1, 1'b1, 1'b0, 6'h2A, 6'b111111, "R7 sel 11");
    powerup(1'b0, 1'b0, 1'b1, 6'h2A, 6'h2A, "R8 bus at power-up");
    powerup(1'b1, 1'b0, 1'b0, 6'h2A, 6'b001111, "R7 sel 01");
    chk("R6 gain -24dB", int'(gain_halfdb), -48);

    // direct parallel table walk
    latch_en = 1'b1; mode_serial = 1'b0;
    for (int i = 0; i < 10; i++) begin
      par_word = VEC[i][12:7];
      cyc(1);
      chk("R4 direct follow", int'(ctrl_word), int'(VEC[i][12:7]));
      chk("R6 gain decode", int'(gain_halfdb), int'($signed(VEC[i][6:0])));
    end

    // latched parallel
    latch_en = 1'b0; par_word = 6'h15;
    cyc(4);
    chk("R5 hold while strobe low", int'(ctrl_word), 'h2A);
    latch_en = 1'b1;
    cyc(1);
    latch_en = 1'b0; par_word = 6'h3F;
    chk("R5 capture on pulse", int'(ctrl_word), 'h15);
    cyc(3);
    chk("R5 hold after pulse", int'(ctrl_word), 'h15);

    // serial load
    mode_serial = 1'b1;
    for (int i = 5; i >= 0; i--) shift_bit(w1[i]);
    chk("R5 serial shift no transfer", int'(ctrl_word), 'h15);
    chk("R10 ser_out is msb", int'(ser_out), int'(w1[5]));
    pulse_le();
    chk("R2 serial transfer", int'(ctrl_word), int'(w1));
    chk("R6 gain serial word", int'(gain_halfdb), -18);

    // clock masked while strobe high
    latch_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ser_data = 1'b0; ser_clk = 1'b1; cyc(1); ser_clk = 1'b0; cyc(1);
    end
    latch_en = 1'b0;
    cyc(1);
    chk("R2 clock masked", int'(ctrl_word), int'(w1));
    chk("R2 ser_out unchanged", int'(ser_out), int'(w1[5]));

    // parallel mode ignores serial pins
    mode_serial = 1'b0;
    for (int i = 0; i < 6; i++) shift_bit(1'b0);
    latch_en = 1'b1; cyc(1); latch_en = 1'b0;
    mode_serial = 1'b1;
    cyc(1);
    pulse_le();
    chk("R3 shift register kept", int'(ctrl_word), int'(w1));

    // daisy chain: first word leaves through ser_out, MSB first
    for (int k = 1; k <= 6; k++) begin
      shift_bit(w2[6-k]);
      if (k < 6) chk("R10 chained bit", int'(ser_out), int'(w1[5-k]));
      else       chk("R10 chained bit", int'(ser_out), int'(w2[5]));
    end
    pulse_le();
    chk("R1 msb-first word", int'(ctrl_word), int'(w2));

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule